// File: doc/BRIEF.md
# Nibble-Stream Receive Frame Synchronizer

This block watches a 4-bit receive nibble bus and its data-valid strobe, and finds where each frame's payload starts. It looks for the first 0x5 nibble, which may come from a full preamble, from a short one, or only from the delimiter. It then waits for the 0xD delimiter nibble. Once frame data begins, it steps between a low-nibble phase and a high-nibble phase until data-valid falls. Downstream logic uses the one-hot state vector and the phase flag to steer nibbles into bytes.

A gap counter measures how many nibble clocks data-valid stayed low since the last frame body. A frame whose delimiter arrives before 24 quiet nibble periods is refused. The machine then parks in a drop state for the rest of that frame and emits a one-cycle drop pulse. A configuration input disables this gap check so that every synchronized frame is taken.

Top module: `mii_rx_framesync`

## Requirements
- R1: While reset is high the drop indicator is the only state bit set. After reset releases, the machine moves to idle on the first clock where data-valid is low.
- R2: The state vector always has exactly one bit set, with this bit map: bit 0 idle, bit 1 drop, bit 2 preamble, bit 3 delimiter-wait, bit 4 data-low, bit 5 data-high.
- R3: In idle or preamble with data-valid high, a 0x5 nibble moves the machine to delimiter-wait. Any other nibble moves it to preamble, or keeps it there.
- R4: In delimiter-wait with data-valid high, another 0x5 keeps the state. A nibble that is neither 0x5 nor 0xD sends the machine back to preamble.
- R5: In delimiter-wait, a 0xD nibble with the gap accepted moves the machine to data-low. It then alternates data-low and data-high on every clock while data-valid is high. The phase output is 1 exactly in data-high.
- R6: In delimiter-wait, a 0xD nibble with the gap refused moves the machine to drop. The drop output is 1 only in that first drop cycle. Drop holds while data-valid stays high.
- R7: From any state, a clock with data-valid low leads to idle on the next cycle.
- R8: The gap counter clears on clocks where data-valid is high in drop or a data state. It adds one on each clock where data-valid is low, stops at 24, and holds during preamble and delimiter-wait. The gap counts as accepted only when the counter is at 24, so 23 quiet clocks are refused and 24 are accepted. The counter is 0 after reset.
- R9: With the ignore-gap input high, the gap always counts as accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 4 | Receive nibble, least significant nibble of each byte first |
| rx_dv | input | 1 | Receive data valid |
| ign_gap | input | 1 | When high, the inter-frame gap check is turned off |
| state_oh | output | 6 | One-hot state vector (bit map in R2) |
| hi_phase | output | 1 | High in the data-high nibble phase |
| frame_drop | output | 1 | One-cycle pulse when a frame is refused for a short gap |

## Verification
The embedded assertions check the cycle-level rules on every clock. These are: the one-hot state vector, the return to idle after a low data-valid, the strict low/high alternation, acceptance at the delimiter when the gap is accepted, the drop pulse appearing only right after delimiter-wait, and the gap counter never passing its limit. Only the bench scenarios can show the counting rules themselves. Those include the exact 23-versus-24 quiet-clock boundary, the counter holding during preamble, resynchronization after a stray nibble in delimiter-wait, frames with no preamble, and the ignore-gap override letting a back-to-back frame through.

// File: rtl/mii_rxsync_pkg.sv
package mii_rxsync_pkg;

    localparam int NIB_W    = 4;
    localparam int N_STATES = 6;

    // enum value equals the bit index in the one-hot output vector
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DROP = 3'd1,
        S_PRE  = 3'd2,
        S_SFD  = 3'd3,
        S_DLO  = 3'd4,
        S_DHI  = 3'd5
    } sync_state_e;

    typedef struct packed {
        logic             valid;
        logic [NIB_W-1:0] nib;
    } rx_beat_t;

    function automatic logic [N_STATES-1:0] state_to_onehot(sync_state_e s);
        return N_STATES'(1) << s;
    endfunction

    function automatic logic is_body(sync_state_e s);
        return (s == S_DLO) || (s == S_DHI) || (s == S_DROP);
    endfunction

endpackage

// File: rtl/mii_rxsync_gapcnt.sv
module mii_rxsync_gapcnt #(
    parameter int GAP_LIMIT = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_dv,
    input  logic in_body,
    input  logic ignore_gap,
    output logic gap_ok
);
    localparam int CW = $clog2(GAP_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(GAP_LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (rx_dv && in_body) begin
            cnt <= '0;
        end else if (!rx_dv && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign gap_ok = ignore_gap || (cnt == LIMIT);

    // R8
    gap_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

    // R8
    gap_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_dv && in_body) |=> !gap_ok || ignore_gap);

endmodule

// File: rtl/mii_rxsync_fsm.sv
module mii_rxsync_fsm
    import mii_rxsync_pkg::*;
#(
    parameter logic [NIB_W-1:0] SYNC_NIB = 4'h5,
    parameter logic [NIB_W-1:0] SFD_NIB  = 4'hD
) (
    input  logic        clk,
    input  logic        rst,
    input  rx_beat_t    beat,
    input  logic        gap_ok,
    output sync_state_e state,
    output logic        drop_pulse,
    output logic        in_body
);
    sync_state_e nxt;
    logic        is_sync;
    logic        is_sfd;

    assign is_sync = (beat.nib == SYNC_NIB);
    assign is_sfd  = (beat.nib == SFD_NIB);

    always_comb begin
        nxt = state;
        if (!beat.valid) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE, S_PRE: nxt = is_sync ? S_SFD : S_PRE;
                S_SFD: begin
                    if (is_sfd)       nxt = gap_ok ? S_DLO : S_DROP;
                    else if (is_sync) nxt = S_SFD;
                    else              nxt = S_PRE;
                end
                S_DLO:   nxt = S_DHI;
                S_DHI:   nxt = S_DLO;
                S_DROP:  nxt = S_DROP;
                default: nxt = S_DROP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_DROP;
            drop_pulse <= 1'b0;
        end else begin
            state      <= nxt;
            drop_pulse <= (state == S_SFD) && beat.valid && is_sfd && !gap_ok;
        end
    end

    assign in_body = is_body(state);

    // R7
    dv_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !beat.valid |=> state == S_IDLE);

    // R5
    lo_to_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_DLO && beat.valid) |=> state == S_DHI);

    // R5
    hi_to_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_DHI && beat.valid) |=> state == S_DLO);

    // R5
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_SFD && beat.valid && is_sfd && gap_ok) |=> state == S_DLO);

    // R6
    drop_origin_chk: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> (state == S_DROP && $past(state) == S_SFD));

endmodule

// File: rtl/mii_rx_framesync.sv
module mii_rx_framesync
    import mii_rxsync_pkg::*;
#(
    parameter int GAP_LIMIT = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NIB_W-1:0]    rxd,
    input  logic                rx_dv,
    input  logic                ign_gap,
    output logic [N_STATES-1:0] state_oh,
    output logic                hi_phase,
    output logic                frame_drop
);
    rx_beat_t    beat;
    sync_state_e state;
    logic        gap_ok;
    logic        in_body;

    assign beat = '{valid: rx_dv, nib: rxd};

    mii_rxsync_gapcnt #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk        (clk),
        .rst        (rst),
        .rx_dv      (rx_dv),
        .in_body    (in_body),
        .ignore_gap (ign_gap),
        .gap_ok     (gap_ok)
    );

    mii_rxsync_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .beat       (beat),
        .gap_ok     (gap_ok),
        .state      (state),
        .drop_pulse (frame_drop),
        .in_body    (in_body)
    );

    assign state_oh = state_to_onehot(state);
    assign hi_phase = (state == S_DHI);

    // R2
    onehot_out_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);

    // R5
    phase_chk: assert property (@(posedge clk) disable iff (rst)
        hi_phase |-> state_oh[5]);

endmodule

// File: tb/mii_rx_framesync_bench.sv
`timescale 1ns/1ps
module mii_rx_framesync_bench;

    localparam int IDLE = 0, DROP = 1, PRE = 2, SFD = 3, DLO = 4, DHI = 5;
    localparam int GAPN = 24;

    typedef struct {
        logic [5:0] oh;
        logic       hi;
        logic       fd;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rxd = 4'h0;
    logic       rx_dv = 1'b0;
    logic       ign_gap = 1'b0;
    logic [5:0] state_oh;
    logic       hi_phase;
    logic       frame_drop;

    int   checks = 0;
    int   errors = 0;
    logic ign_cfg = 1'b0;
    int   m_state = DROP;
    int   m_cnt = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    mii_rx_framesync u_mii_rx_framesync (
        .clk(clk), .rst(rst), .rxd(rxd), .rx_dv(rx_dv), .ign_gap(ign_gap),
        .state_oh(state_oh), .hi_phase(hi_phase), .frame_drop(frame_drop)
    );

    task automatic drive(input logic dv, input logic [3:0] nib, input string req);
        int   ns;
        logic ok;
        logic fd;
        exp_t e;
        @(negedge clk);
        rx_dv = dv; rxd = nib; ign_gap = ign_cfg;
        ok = ign_cfg || (m_cnt >= GAPN);
        fd = 1'b0;
        ns = m_state;
        if (!dv) ns = IDLE;
        else case (m_state)
            IDLE, PRE: ns = (nib == 4'h5) ? SFD : PRE;
            SFD: begin
                if (nib == 4'hD) begin ns = ok ? DLO : DROP; fd = !ok; end
                else if (nib == 4'h5) ns = SFD;
                else ns = PRE;
            end
            DLO: ns = DHI;
            DHI: ns = DLO;
            default: ns = DROP;
        endcase
        if (dv && (m_state == DLO || m_state == DHI || m_state == DROP)) m_cnt = 0;
        else if (!dv && m_cnt < GAPN) m_cnt++;
        m_state = ns;
        e.oh = 6'(1) << ns; e.hi = (ns == DHI); e.fd = fd; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) drive(1'b0, 4'h0, req);
    endtask

    task automatic data(input int n, input string req);
        for (int i = 0; i < n; i++) drive(1'b1, 4'(i * 3 + 1), req);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk); #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (state_oh !== e.oh || hi_phase !== e.hi || frame_drop !== e.fd) begin
                    errors++;
                    $display("FAIL %s: state_oh=%b hi=%b drop=%b expected %b %b %b",
                             e.req, state_oh, hi_phase, frame_drop, e.oh, e.hi, e.fd);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        // R1: reset holds drop even with valid data present
        rx_dv = 1'b1; rxd = 4'h5;
        repeat (3) @(negedge clk);
        checks++;
        if (state_oh !== 6'b000010 || frame_drop !== 1'b0) begin
            errors++;
            $display("FAIL R1: state_oh=%b drop=%b expected 000010 0", state_oh, frame_drop);
        end
        rst = 1'b0;
        m_state = DROP; m_cnt = 0;
        // R1: stays drop while dv high, then idle on dv low
        drive(1'b1, 4'h5, "R1");
        quiet(30, "R1");
        // R3 R5: full preamble then accepted frame
        for (int i = 0; i < 15; i++) drive(1'b1, 4'h5, "R3");
        drive(1'b1, 4'hD, "R5");
        data(9, "R5");
        // R6: back-to-back frame refused
        quiet(3, "R7");
        drive(1'b1, 4'h5, "R3");
        drive(1'b1, 4'hD, "R6");
        data(6, "R6");
        quiet(30, "R7");
        // R3 R4: no preamble, junk, repeated sync, fallback to preamble
        drive(1'b1, 4'hD, "R3");
        drive(1'b1, 4'hA, "R3");
        drive(1'b1, 4'h0, "R3");
        drive(1'b1, 4'h5, "R3");
        drive(1'b1, 4'h5, "R4");
        drive(1'b1, 4'h5, "R4");
        drive(1'b1, 4'h3, "R4");
        drive(1'b1, 4'h5, "R3");
        drive(1'b1, 4'hD, "R5");
        data(4, "R5");
        // R8: exactly 23 quiet clocks -> refused
        quiet(23, "R8");
        drive(1'b1, 4'h5, "R8");
        drive(1'b1, 4'hD, "R8");
        data(3, "R8");
        // R8: exactly 24 quiet clocks, preamble does not reset the count
        quiet(24, "R8");
        for (int i = 0; i < 6; i++) drive(1'b1, 4'h5, "R8");
        drive(1'b1, 4'hD, "R8");
        data(5, "R8");
        // R9: ignore-gap lets a back-to-back frame through
        ign_cfg = 1'b1;
        quiet(2, "R9");
        drive(1'b1, 4'h5, "R9");
        drive(1'b1, 4'hD, "R9");
        data(4, "R9");
        ign_cfg = 1'b0;
        // R7: dv falls in preamble and in delimiter-wait
        quiet(2, "R7");
        drive(1'b1, 4'h1, "R7");
        drive(1'b0, 4'h0, "R7");
        drive(1'b1, 4'h5, "R7");
        drive(1'b0, 4'h0, "R7");
        quiet(2, "R7");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule